// File: doc/BRIEF.md
# Snoop Filter Invalidation Sequencer

This block lets software run a coherent write-back invalidation of two snoop filters through a small register interface. One filter tracks lines held for an external memory. The other tracks lines held for an on-chip SRAM. When software sets a trigger bit, the sequencer walks every entry of the chosen filter in index order. For each valid entry it first asks all coherent masters to drop the line and waits for their acknowledge. If the entry is dirty, it then requests a write-back to the memory that owns the line and waits for that acknowledge. It then clears the entry. A busy bit in the control register stays high until every requested walk has finished.

The entry index counter is shared with a cache-resize engine that sits outside this block. The two users lock each other out. A resize start is granted only while the sequencer is idle. Trigger writes are dropped while a resize runs. While the sequencer is busy, trigger writes and cache-size writes are dropped. If a resize start and a trigger write arrive in the same cycle, the trigger wins. The filter arrays, the memory controllers and the fabric all sit outside the block. The block reaches them through the entry lookup port, the snoop handshake and the write-back handshake. Normal traffic keeps running during a walk. Entries the walker has passed are invalid. Entries it has not reached yet keep their state.

FSM states: `ST_IDLE`, `ST_LOOKUP`, `ST_SNOOP`, `ST_WBACK`, `ST_CLEAR`.

FSM transitions:
- IDLE→LOOKUP on an accepted trigger.
- LOOKUP→SNOOP on a valid entry.
- LOOKUP→LOOKUP on an invalid entry that is not the last one.
- SNOOP→WBACK on a snoop acknowledge when the entry is dirty.
- SNOOP→CLEAR on a snoop acknowledge when the entry is clean.
- WBACK→CLEAR on a write-back acknowledge.
- CLEAR→LOOKUP to advance to the next entry.
- LOOKUP or CLEAR →LOOKUP on the last external entry when an internal walk is pending. The index restarts at 0 on the internal filter.
- LOOKUP or CLEAR →IDLE on the last entry otherwise.

Top module: `sf_inval_seq`

## Requirements
- R1: Writing CTRL (address 0) with bit 0 set, from idle, walks the external filter (`flt_sel`=0) over indices 0 to ENTRIES-1. Each write-back in this walk targets the external memory (`flt_sel`=0).
- R2: Writing CTRL with bit 1 set, from idle, walks the internal SRAM filter (`flt_sel`=1). Each write-back in this walk targets the SRAM.
- R3: When bits 0 and 1 are set in the same write, the whole external walk completes before the internal walk starts at index 0. No external snoop follows any internal snoop.
- R4: A valid entry raises `snp_req`, which stays high until the cycle `snp_ack` is seen. An invalid entry raises no request and is passed in one cycle.
- R5: For a dirty entry, `wb_req` rises after the snoop acknowledge and stays high until `wb_ack`. A clean entry gets no write-back. `ent_clr` pulses for one cycle after the last acknowledge of the entry, and then the index advances.
- R6: The busy bit (CTRL bit 2) reads 1 from the cycle after a trigger is accepted until all requested walks are done. It then returns to 0.
- R7: While busy, writes to either trigger bit are ignored. While busy, writes to the cache-size register (address 1, bits SIZE_W-1:0) are ignored. When idle, a cache-size write is stored and read back.
- R8: While `resize_busy` is 1, trigger writes are ignored.
- R9: `resize_gnt` is asserted only while the sequencer is idle and no trigger is accepted in the same cycle. A trigger that coincides with `resize_req` wins.
- R10: The shared index `walk_idx` resets to 0 on a resize grant. While `resize_busy` is 1, it advances by one on each `resize_step`, wrapping after ENTRIES-1.
- R11: Trigger bits read back as 0. Writing 0 to them has no effect.
- R12: A walk changes only the entries it visits. A filter that was not selected is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 = CTRL, 1 = SIZE) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| resize_req | input | 1 | Resize engine start request |
| resize_gnt | output | 1 | Resize start granted |
| resize_busy | input | 1 | Resize engine running |
| resize_step | input | 1 | Resize engine advances the shared index |
| cache_size | output | SIZE_W | Stored cache-size field |
| walk_idx | output | IDX_W | Shared entry index |
| flt_sel | output | 1 | Filter being walked (0 external, 1 internal); also the write-back target |
| ent_valid | input | 1 | Valid bit of entry `walk_idx` in filter `flt_sel` |
| ent_dirty | input | 1 | Dirty bit of that entry |
| ent_clr | output | 1 | Clear the entry at `walk_idx` |
| snp_req | output | 1 | Invalidate request to coherent masters |
| snp_ack | input | 1 | Masters have invalidated the line |
| wb_req | output | 1 | Write-back request for a dirty line |
| wb_ack | input | 1 | Write-back complete |

## Verification
Some properties are checked on every clock cycle. These are the request-hold rules of both handshakes and the rule that a write-back only follows a snoop acknowledge. Others are the one-cycle skip of invalid entries, the clear pulse after the final acknowledge, and the external-to-internal order of the filter select. The lockout rules are also checked each cycle: no grant while busy, no trigger while a resize runs, and a stable cache size while busy. The bench alone can show the results of a whole walk. These include the count of snoops and write-backs per filter and both arrays being empty after a walk. They also include leaving the unselected filter untouched and dropping a mid-walk trigger. The index movement under the resize engine is also a bench-only result.

// File: rtl/sfinv_pkg.sv
package sfinv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SNOOP,
        ST_WBACK,
        ST_CLEAR
    } walk_st_e;

    typedef enum logic {
        FLT_EXT = 1'b0,
        FLT_INT = 1'b1
    } flt_e;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_SIZE = 1;
    localparam int BIT_GO_EXT = 0;
    localparam int BIT_GO_INT = 1;
    localparam int BIT_BUSY   = 2;
endpackage

// File: rtl/sfinv_regs.sv
module sfinv_regs
    import sfinv_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              resize_req,
    input  logic              resize_busy,
    output logic              resize_gnt,
    output logic              go_ext,
    output logic              go_int,
    output logic [SIZE_W-1:0] cache_size
);
    logic ctrl_wr;
    logic size_wr;
    logic trig_ok;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
    assign size_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_SIZE));
    assign trig_ok = ctrl_wr && !busy && !resize_busy;

    assign go_ext = trig_ok && reg_wdata[BIT_GO_EXT];
    assign go_int = trig_ok && reg_wdata[BIT_GO_INT];

    // invalidation wins a same-cycle conflict
    assign resize_gnt = resize_req && !busy && !resize_busy && !go_ext && !go_int;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cache_size <= '0;
        end else if (size_wr && !busy) begin
            cache_size <= reg_wdata[SIZE_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata[BIT_BUSY] = busy;
        end else if (reg_addr == ADDR_W'(ADDR_SIZE)) begin
            reg_rdata[SIZE_W-1:0] = cache_size;
        end
    end

    AST_GNT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        resize_gnt |-> (!busy && !go_ext && !go_int)); // R9
    AST_NO_GO_IN_RESIZE: assert property (@(posedge clk) disable iff (!rst_n)
        resize_busy |-> !(go_ext || go_int)); // R8
    AST_SIZE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cache_size)); // R7
endmodule

// File: rtl/sfinv_walker.sv
module sfinv_walker
    import sfinv_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_ext,
    input  logic             go_int,
    input  logic             resize_gnt,
    input  logic             resize_busy,
    input  logic             resize_step,
    input  logic             ent_valid,
    input  logic             ent_dirty,
    input  logic             snp_ack,
    input  logic             wb_ack,
    output logic [IDX_W-1:0] walk_idx,
    output logic             flt_sel,
    output logic             ent_clr,
    output logic             snp_req,
    output logic             wb_req,
    output logic             busy
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    walk_st_e         st_q, st_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    flt_e             sel_q, sel_n;
    logic             pend_q, pend_n;
    logic             dirty_q, dirty_n;
    logic             adv;

    // next-state logic
    always_comb begin
        st_n    = st_q;
        idx_n   = idx_q;
        sel_n   = sel_q;
        pend_n  = pend_q;
        dirty_n = dirty_q;
        adv     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (go_ext || go_int) begin
                    st_n   = ST_LOOKUP;
                    idx_n  = '0;
                    sel_n  = go_ext ? FLT_EXT : FLT_INT;
                    pend_n = go_ext && go_int;
                end else if (resize_gnt) begin
                    idx_n = '0;
                end else if (resize_busy && resize_step) begin
                    idx_n = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
                end
            end
            ST_LOOKUP: begin
                if (ent_valid) begin
                    dirty_n = ent_dirty;
                    st_n    = ST_SNOOP;
                end else begin
                    adv = 1'b1;
                end
            end
            ST_SNOOP: begin
                if (snp_ack) begin
                    st_n = dirty_q ? ST_WBACK : ST_CLEAR;
                end
            end
            ST_WBACK: begin
                if (wb_ack) begin
                    st_n = ST_CLEAR;
                end
            end
            ST_CLEAR: begin
                adv = 1'b1;
            end
            default: st_n = ST_IDLE;
        endcase

        if (adv) begin
            if (idx_q == LAST_IDX) begin
                if (sel_q == FLT_EXT && pend_q) begin
                    sel_n  = FLT_INT;
                    pend_n = 1'b0;
                    idx_n  = '0;
                    st_n   = ST_LOOKUP;
                end else begin
                    st_n = ST_IDLE;
                end
            end else begin
                idx_n = idx_q + 1'b1;
                st_n  = ST_LOOKUP;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            idx_q   <= '0;
            sel_q   <= FLT_EXT;
            pend_q  <= 1'b0;
            dirty_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            idx_q   <= idx_n;
            sel_q   <= sel_n;
            pend_q  <= pend_n;
            dirty_q <= dirty_n;
        end
    end

    // outputs
    always_comb begin
        walk_idx = idx_q;
        flt_sel  = sel_q;
        busy     = (st_q != ST_IDLE);
        snp_req  = (st_q == ST_SNOOP);
        wb_req   = (st_q == ST_WBACK);
        ent_clr  = (st_q == ST_CLEAR);
    end

    AST_SNP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && !snp_ack) |=> snp_req); // R4
    AST_SKIP_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOOKUP && !ent_valid) |=> !snp_req); // R4
    AST_WB_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_req) |-> $past(snp_ack)); // R5
    AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> wb_req); // R5
    AST_CLR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ent_clr |-> $past(snp_ack || wb_ack)); // R5
    AST_EXT_THEN_INT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$stable(flt_sel)) |-> (flt_sel == FLT_INT)); // R3
endmodule

// File: rtl/sf_inval_seq.sv
module sf_inval_seq
    import sfinv_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 32,
    parameter int SIZE_W  = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              resize_req,
    output logic              resize_gnt,
    input  logic              resize_busy,
    input  logic              resize_step,
    output logic [SIZE_W-1:0] cache_size,
    output logic [IDX_W-1:0]  walk_idx,
    output logic              flt_sel,
    input  logic              ent_valid,
    input  logic              ent_dirty,
    output logic              ent_clr,
    output logic              snp_req,
    input  logic              snp_ack,
    output logic              wb_req,
    input  logic              wb_ack
);
    logic busy;
    logic go_ext;
    logic go_int;

    sfinv_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SIZE_W(SIZE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .resize_req (resize_req),
        .resize_busy(resize_busy),
        .resize_gnt (resize_gnt),
        .go_ext     (go_ext),
        .go_int     (go_int),
        .cache_size (cache_size)
    );

    sfinv_walker #(
        .ENTRIES(ENTRIES)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_ext     (go_ext),
        .go_int     (go_int),
        .resize_gnt (resize_gnt),
        .resize_busy(resize_busy),
        .resize_step(resize_step),
        .ent_valid  (ent_valid),
        .ent_dirty  (ent_dirty),
        .snp_ack    (snp_ack),
        .wb_ack     (wb_ack),
        .walk_idx   (walk_idx),
        .flt_sel    (flt_sel),
        .ent_clr    (ent_clr),
        .snp_req    (snp_req),
        .wb_req     (wb_req),
        .busy       (busy)
    );
endmodule

// File: tb/sf_inval_seq_bench.sv
module sf_inval_seq_bench;
    localparam int N = 16;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic resize_req = 1'b0, resize_busy = 1'b0, resize_step = 1'b0;
    logic resize_gnt;
    logic [2:0] cache_size;
    logic [IW-1:0] walk_idx;
    logic flt_sel, ent_clr, snp_req, wb_req;
    logic snp_ack = 1'b0, wb_ack = 1'b0;
    logic ent_valid, ent_dirty;

    logic [N-1:0] fv [2];
    logic [N-1:0] fd [2];
    logic [N-1:0] sv [2];
    logic [N-1:0] sd [2];
    int snp_cnt [2];
    int wb_cnt [2];
    int bad_cnt;
    logic seen_int;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign ent_valid = fv[flt_sel][walk_idx];
    assign ent_dirty = fd[flt_sel][walk_idx];

    sf_inval_seq u_sf_inval_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .resize_req(resize_req),
        .resize_gnt(resize_gnt), .resize_busy(resize_busy), .resize_step(resize_step),
        .cache_size(cache_size), .walk_idx(walk_idx), .flt_sel(flt_sel),
        .ent_valid(ent_valid), .ent_dirty(ent_dirty), .ent_clr(ent_clr),
        .snp_req(snp_req), .snp_ack(snp_ack), .wb_req(wb_req), .wb_ack(wb_ack)
    );

    // acknowledge responders with random latency
    always @(negedge clk) begin
        snp_ack <= snp_req && ($urandom % 3 == 0);
        wb_ack  <= wb_req && ($urandom % 4 == 0);
    end

    // filter model and monitor
    always @(posedge clk) begin
        if (snp_req && snp_ack) begin
            snp_cnt[flt_sel] <= snp_cnt[flt_sel] + 1;
            if (!fv[flt_sel][walk_idx]) bad_cnt <= bad_cnt + 1;
            if (flt_sel == 1'b0 && seen_int) bad_cnt <= bad_cnt + 1;
            if (flt_sel == 1'b1) seen_int <= 1'b1;
        end
        if (wb_req && wb_ack) begin
            wb_cnt[flt_sel] <= wb_cnt[flt_sel] + 1;
            if (!fd[flt_sel][walk_idx]) bad_cnt <= bad_cnt + 1;
        end
        if (ent_clr) begin
            fv[flt_sel][walk_idx] <= 1'b0;
            fd[flt_sel][walk_idx] <= 1'b0;
        end
    end

    function automatic int popc(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = '0;
    endtask

    task automatic fill(input int f);
        logic [N-1:0] v = N'($urandom);
        fv[f] = v;
        fd[f] = v & N'($urandom);
    endtask

    task automatic wait_idle(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            reg_addr = 2'd0;
            #1;
            if (!reg_rdata[2]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic run(input logic [1:0] bits, input string tag);
        bit ok;
        int ev [2];
        int ed [2];
        for (int f = 0; f < 2; f++) begin
            sv[f] = fv[f]; sd[f] = fd[f];
            ev[f] = bits[f] ? popc(fv[f]) : 0;
            ed[f] = bits[f] ? popc(fd[f]) : 0;
            snp_cnt[f] = 0; wb_cnt[f] = 0;
        end
        bad_cnt = 0; seen_int = 1'b0;
        wr(2'd0, {30'd0, bits});
        wait_idle(ok);
        chk(ok, {tag, " R6 busy returns to 0"}, int'(ok), 1);
        for (int f = 0; f < 2; f++) begin
            chk(snp_cnt[f] == ev[f], {tag, " R4 snoop count"}, snp_cnt[f], ev[f]);
            chk(wb_cnt[f] == ed[f], {tag, " R5 write-back count"}, wb_cnt[f], ed[f]);
            if (bits[f])
                chk(fv[f] == '0, {tag, " R1/R2 filter emptied"}, int'(fv[f]), 0);
            else
                chk(fv[f] == sv[f] && fd[f] == sd[f], {tag, " R12 unselected untouched"},
                    int'(fv[f]), int'(sv[f]));
        end
        chk(bad_cnt == 0, {tag, " R3 order and target"}, bad_cnt, 0);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ok;
        void'($urandom(32'd2024));
        fv[0] = '0; fv[1] = '0; fd[0] = '0; fd[1] = '0;
        snp_cnt[0] = 0; snp_cnt[1] = 0; wb_cnt[0] = 0; wb_cnt[1] = 0;
        bad_cnt = 0; seen_int = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(reg_rdata == 0, "R6 reset busy", int'(reg_rdata), 0);
        chk(!snp_req && !wb_req && !ent_clr, "R4 reset no requests", int'(snp_req), 0);
        chk(walk_idx == 0, "R10 reset index", int'(walk_idx), 0);

        // R11: writing zero does nothing
        wr(2'd0, 32'd0);
        #1;
        chk(reg_rdata[2] == 1'b0, "R11 zero write no start", int'(reg_rdata[2]), 0);

        // directed: each mode
        fill(0); fill(1); run(2'b01, "ext R1");
        fill(0); fill(1); run(2'b10, "int R2");
        fill(0); fill(1); run(2'b11, "both R3");
        // all-clean and all-dirty corners
        fv[0] = '1; fd[0] = '0; fv[1] = '1; fd[1] = '1; run(2'b11, "corner R5");
        fv[0] = '0; fd[0] = '0; fv[1] = '0; fd[1] = '0; run(2'b11, "empty R4");

        // random modes
        for (int k = 0; k < 6; k++) begin
            logic [1:0] b = 2'(1 + ($urandom % 3));
            fill(0); fill(1);
            run(b, "random");
        end

        // R7/R11/R12: writes ignored while busy
        wr(2'd1, 32'd5);
        #1 reg_addr = 2'd1; #1;
        chk(cache_size == 3'd5, "R7 size stored idle", int'(cache_size), 5);
        fv[0] = '1; fd[0] = '1; fill(1);
        sv[1] = fv[1]; sd[1] = fd[1];
        wr(2'd0, 32'd1);
        #1;
        chk(reg_rdata[1:0] == 2'b00 && reg_rdata[2], "R11 trigger bits read 0, R6 busy", int'(reg_rdata), 4);
        wr(2'd0, 32'd2);
        wr(2'd1, 32'd2);
        #1;
        chk(cache_size == 3'd5, "R7 size ignored busy", int'(cache_size), 5);
        @(negedge clk); resize_req = 1'b1; #1;
        chk(!resize_gnt, "R9 no grant while busy", int'(resize_gnt), 0);
        resize_req = 1'b0;
        wait_idle(ok);
        chk(fv[1] == sv[1] && fd[1] == sd[1], "R7 R12 int trigger ignored busy", int'(fv[1]), int'(sv[1]));

        // R9/R10: resize grant and shared index
        @(negedge clk); resize_req = 1'b1; #1;
        chk(resize_gnt, "R9 grant when idle", int'(resize_gnt), 1);
        @(negedge clk); resize_req = 1'b0; resize_busy = 1'b1;
        #1;
        chk(walk_idx == 0, "R10 index zero after grant", int'(walk_idx), 0);
        resize_step = 1'b1;
        repeat (3) @(negedge clk);
        resize_step = 1'b0; #1;
        chk(walk_idx == 3, "R10 index steps", int'(walk_idx), 3);
        fill(0); sv[0] = fv[0];
        reg_addr = 2'd0; reg_wdata = 32'd3; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0; #1;
        chk(reg_rdata[2] == 1'b0, "R8 trigger ignored during resize", int'(reg_rdata[2]), 0);
        resize_step = 1'b1;
        repeat (N) @(negedge clk);
        resize_step = 1'b0; #1;
        chk(walk_idx == 3, "R10 index wraps", int'(walk_idx), 3);
        chk(fv[0] == sv[0], "R8 filter untouched", int'(fv[0]), int'(sv[0]));
        resize_busy = 1'b0;

        // R9: same-cycle conflict, invalidation wins
        fv[0] = '0; fd[0] = '0; fv[1] = '0; fd[1] = '0;
        @(negedge clk);
        resize_req = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd1; reg_wr = 1'b1; #1;
        chk(!resize_gnt, "R9 trigger wins conflict", int'(resize_gnt), 0);
        @(negedge clk); reg_wr = 1'b0; #1;
        chk(reg_rdata[2] == 1'b1, "R9 R6 invalidation started", int'(reg_rdata[2]), 1);
        resize_req = 1'b0;
        wait_idle(ok);
        chk(ok, "R6 conflict walk ends", int'(ok), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule